// File: doc/BRIEF.md
# Indexed Block-Access Serial Configuration Slave

This block is a serial-bus slave that lets a host read and write a small bank of byte-wide configuration registers. Each transfer names a starting register index. A write also carries a byte count, followed by that many data bytes. A read returns the value held in the count register first, and then the register contents from the starting index onward. The bank is exposed as a flat parallel output for the logic that uses the settings.

The serial clock and data lines are oversampled by a faster system clock. Each line passes through a two-stage synchronizer, and then edge detection finds clock rises, clock falls, start conditions and stop conditions. The slave pulls the data line low through an open-drain enable (`sda_oe` high means pull low) and never drives it high.

The controller is one enumerated state machine:
- `ST_IDLE`: waits for a start.
- `ST_ADDR`: shifts in the address byte. A match goes to `ST_ADDR_ACK`. A mismatch goes to `ST_PARK`.
- `ST_ADDR_ACK`: after the acknowledge, goes to `ST_INDEX` for a write or to `ST_TX` for a read.
- `ST_INDEX`: shifts in the index, then `ST_INDEX_ACK` leads to `ST_COUNT`.
- `ST_COUNT`: shifts in the count, then `ST_COUNT_ACK` leads to `ST_WDATA`.
- `ST_WDATA`: shifts in a data byte. If count budget remains, it goes to `ST_WDATA_ACK` and back to `ST_WDATA`. If none remains, it goes to `ST_PARK`.
- `ST_TX`: shifts a byte out, then `ST_TX_ACK` samples the host's answer. An acknowledge returns to `ST_TX`. A not-acknowledge goes to `ST_PARK`.
- In every state, a stop goes to `ST_IDLE` and a start goes to `ST_ADDR`.

Top module: `smb_blockcfg_slave`

## Requirements
- R1: After reset every register reads 0 except index 8, which reads 16 (0x10), and `sda_oe` is 0.
- R2: The address byte 0xD0 (write) or 0xD1 (read) is acknowledged. Any other address byte is not acknowledged, and the slave drives nothing and changes no register until the next start.
- R3: In a write, the index byte, the count byte X and each of the first X data bytes are acknowledged. Data byte k (k from 0) is stored at index (N+k) mod 16, where N is the index byte's low 4 bits. An acknowledge is a low data line during the ninth clock of a byte.
- R4: Data bytes past the count X are not acknowledged and are not stored. With X = 0, the first data byte is already refused.
- R5: A read is start, 0xD0, index N, repeated start, 0xD1. The slave then sends, MSB first, the value of register 8, followed by registers N, N+1, … mod 16. The index from the write phase is kept across the repeated start.
- R6: When the host does not acknowledge a byte it reads, the slave releases the data line at once and sends nothing more until the next start or stop.
- R7: A start or stop in the middle of a transfer ends it. Bytes already acknowledged stay stored, and the slave is ready for a new address byte after a start.
- R8: Register 8 can be written like any other register, and its new value is the count byte returned by later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus (wired-AND level) |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |
| cfg_flat | output | 128 | Register bank, register i at bits [8i+7:8i] |

## Verification
The assertions rely on these properties of the bus inputs:
- SCL stays low and stays high for several system clocks at a time, longer than the synchronizer delay plus one state update, so that the data line is only ever pulled low while the synchronized clock is low.
- The host changes SDA only while SCL is low, except for intended start and stop conditions.
- SDA is the wired-AND of the host's drive and the slave's enable.

The stimulus drives the lines in phases of ten system clocks and changes SDA only at or after a clock fall. It forms SDA as the AND of the host level and the inverted `sda_oe`, so every acknowledge and transmitted bit is seen on the shared line, as on a real bus.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;

    localparam int OCTET_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INDEX,
        ST_INDEX_ACK,
        ST_COUNT,
        ST_COUNT_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_PARK
    } xfer_state_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Metastability stages; the idle bus level is high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
        end
    end

    assign scl_lvl = scl_pipe[STAGES-1];
    assign sda_lvl = sda_pipe[STAGES-1];

    // One more stage gives the previous level for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_lvl;
            sda_d <= sda_lvl;
        end
    end

    assign scl_rise  = scl_lvl & ~scl_d;
    assign scl_fall  = ~scl_lvl & scl_d;
    assign start_evt = scl_lvl & scl_d & sda_d & ~sda_lvl;
    assign stop_evt  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/smb_cfg_bank.sv
module smb_cfg_bank #(
    parameter int                 NREGS     = 16,
    parameter int                 BYTE_W    = 8,
    parameter int                 CNT_IDX   = 8,
    parameter logic [BYTE_W-1:0]  CNT_RESET = 8'd16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [$clog2(NREGS)-1:0]    waddr,
    input  logic [BYTE_W-1:0]           wdata,
    output logic [NREGS*BYTE_W-1:0]     regs_flat
);

    localparam int IDX_W = $clog2(NREGS);

    logic [BYTE_W-1:0] mem [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        localparam logic [BYTE_W-1:0] RST_VAL = (g == CNT_IDX) ? CNT_RESET : '0;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[g] <= RST_VAL;
            end else if (we && waddr == IDX_W'(g)) begin
                mem[g] <= wdata;
            end
        end

        assign regs_flat[g*BYTE_W +: BYTE_W] = mem[g];
    end

    // R3: an accepted data byte is visible at its index on the next cycle
    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
    import smbcfg_pkg::*;
#(
    parameter int          NREGS    = 16,
    parameter int          BYTE_W   = 8,
    parameter logic [6:0]  DEV_ADDR = 7'h68,
    parameter int          CNT_IDX  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        scl_lvl,
    input  logic                        sda_lvl,
    input  logic                        scl_rise,
    input  logic                        scl_fall,
    input  logic                        start_evt,
    input  logic                        stop_evt,
    input  logic [NREGS*BYTE_W-1:0]     regs_flat,
    output logic                        we,
    output logic [$clog2(NREGS)-1:0]    waddr,
    output logic [BYTE_W-1:0]           wdata,
    output logic                        sda_oe
);

    localparam int IDX_W = $clog2(NREGS);
    localparam int BC_W  = $clog2(BYTE_W) + 1;

    xfer_state_t        state, state_nx;
    logic [BYTE_W-1:0]  rx_sh;
    logic [BYTE_W-1:0]  tx_sh;
    logic [BC_W-1:0]    bitcnt;
    logic [IDX_W-1:0]   ptr;
    logic [BYTE_W-1:0]  wr_left;
    logic               rw_bit;

    logic byte_in;
    logic tx_last;
    logic addr_hit;
    logic rx_state;

    assign byte_in  = (bitcnt == BC_W'(BYTE_W)) && scl_fall;
    assign tx_last  = (bitcnt == BC_W'(BYTE_W - 1)) && scl_fall;
    assign addr_hit = (rx_sh[BYTE_W-1:1] == DEV_ADDR);
    assign rx_state = (state == ST_ADDR) || (state == ST_INDEX) ||
                      (state == ST_COUNT) || (state == ST_WDATA);

    function automatic logic [BYTE_W-1:0] reg_at(input logic [IDX_W-1:0] idx);
        return regs_flat[int'(idx)*BYTE_W +: BYTE_W];
    endfunction

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (stop_evt) begin
            state_nx = ST_IDLE;
        end else if (start_evt) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE, ST_PARK: begin
                end
                ST_ADDR: begin
                    if (byte_in) state_nx = addr_hit ? ST_ADDR_ACK : ST_PARK;
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) state_nx = rw_bit ? ST_TX : ST_INDEX;
                end
                ST_INDEX: begin
                    if (byte_in) state_nx = ST_INDEX_ACK;
                end
                ST_INDEX_ACK: begin
                    if (scl_fall) state_nx = ST_COUNT;
                end
                ST_COUNT: begin
                    if (byte_in) state_nx = ST_COUNT_ACK;
                end
                ST_COUNT_ACK: begin
                    if (scl_fall) state_nx = ST_WDATA;
                end
                ST_WDATA: begin
                    if (byte_in) state_nx = (wr_left != '0) ? ST_WDATA_ACK : ST_PARK;
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) state_nx = ST_WDATA;
                end
                ST_TX: begin
                    if (tx_last) state_nx = ST_TX_ACK;
                end
                ST_TX_ACK: begin
                    if (scl_rise && sda_lvl) state_nx = ST_PARK;
                    else if (scl_fall)       state_nx = ST_TX;
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Byte store strobe
    assign we    = (state == ST_WDATA) && byte_in && (wr_left != '0);
    assign waddr = ptr;
    assign wdata = rx_sh;

    // Datapath: bit counter, shifters, index pointer, write budget
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt  <= '0;
            rx_sh   <= '0;
            tx_sh   <= '1;
            ptr     <= '0;
            wr_left <= '0;
            rw_bit  <= 1'b0;
        end else begin
            if (start_evt || state_nx != state) begin
                bitcnt <= '0;
            end else if ((scl_rise && rx_state && bitcnt < BC_W'(BYTE_W)) ||
                         (scl_fall && state == ST_TX)) begin
                bitcnt <= bitcnt + 1'b1;
            end

            if (scl_rise && rx_state && bitcnt < BC_W'(BYTE_W)) begin
                rx_sh <= {rx_sh[BYTE_W-2:0], sda_lvl};
            end

            if (state == ST_ADDR && byte_in) begin
                rw_bit <= rx_sh[0];
            end

            if (state == ST_INDEX && byte_in) begin
                ptr <= rx_sh[IDX_W-1:0];
            end

            if (state == ST_COUNT && byte_in) begin
                wr_left <= rx_sh;
            end

            if (we) begin
                ptr     <= ptr + 1'b1;
                wr_left <= wr_left - 1'b1;
            end

            if (state == ST_ADDR_ACK && state_nx == ST_TX) begin
                tx_sh <= reg_at(IDX_W'(CNT_IDX));
            end else if (state == ST_TX_ACK && state_nx == ST_TX) begin
                tx_sh <= reg_at(ptr);
                ptr   <= ptr + 1'b1;
            end else if (state == ST_TX && state_nx == ST_TX && scl_fall) begin
                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b1};
            end
        end
    end

    // Output logic
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_INDEX_ACK, ST_COUNT_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_TX:                                                 sda_oe = ~tx_sh[BYTE_W-1];
            default:                                               sda_oe = 1'b0;
        endcase
    end

    // R7: a stop always brings the slave back to idle
    a_r7_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> state == ST_IDLE);

    // R7: a start rearms address reception from bit zero
    a_r7_start_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state == ST_ADDR) && (bitcnt == '0));

    // R2: a foreign address leaves the slave parked
    a_r2_mismatch_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && byte_in && !addr_hit) |=> state == ST_PARK);

    // R2: the line is only pulled low while the clock is low
    a_r2_pull_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_lvl);

    // R3: every stored byte advances the index by one
    a_r3_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ptr == $past(ptr) + 1'b1);

    // R4: a data byte with no budget left is refused
    a_r4_excess_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA && byte_in && wr_left == '0) |=> (state == ST_PARK) && !sda_oe);

    // R6: a host not-acknowledge releases the line immediately
    a_r6_nack_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX_ACK && scl_rise && sda_lvl) |=> (state == ST_PARK) && !sda_oe);

endmodule

// File: rtl/smb_blockcfg_slave.sv
module smb_blockcfg_slave #(
    parameter int          NREGS       = 16,
    parameter logic [6:0]  DEV_ADDR    = 7'h68,
    parameter int          CNT_IDX     = 8,
    parameter logic [7:0]  CNT_RESET   = 8'd16,
    parameter int          SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_in,
    input  logic                 sda_in,
    output logic                 sda_oe,
    output logic [NREGS*8-1:0]   cfg_flat
);

    localparam int BYTE_W = smbcfg_pkg::OCTET_W;
    localparam int IDX_W  = $clog2(NREGS);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
    logic              bank_we;
    logic [IDX_W-1:0]  bank_waddr;
    logic [BYTE_W-1:0] bank_wdata;

    smb_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    smb_xfer_fsm #(
        .NREGS    (NREGS),
        .BYTE_W   (BYTE_W),
        .DEV_ADDR (DEV_ADDR),
        .CNT_IDX  (CNT_IDX)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .regs_flat (cfg_flat),
        .we        (bank_we),
        .waddr     (bank_waddr),
        .wdata     (bank_wdata),
        .sda_oe    (sda_oe)
    );

    smb_cfg_bank #(
        .NREGS     (NREGS),
        .BYTE_W    (BYTE_W),
        .CNT_IDX   (CNT_IDX),
        .CNT_RESET (CNT_RESET)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bank_we),
        .waddr     (bank_waddr),
        .wdata     (bank_wdata),
        .regs_flat (cfg_flat)
    );

endmodule

// File: tb/smb_blockcfg_slave_bench.sv
module smb_blockcfg_slave_bench;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam int NR         = 16;
    localparam int WD_CYCLES  = 190000;
    localparam int NV         = 7;

    // {index, count, bytes sent, first data, data step}
    localparam logic [39:0] VEC [NV] = '{
        {8'd0,  8'd4, 8'd4, 8'h11, 8'h11},
        {8'd9,  8'd5, 8'd5, 8'hA0, 8'h03},
        {8'd14, 8'd4, 8'd4, 8'h5C, 8'h01},
        {8'd2,  8'd2, 8'd4, 8'h77, 8'h02},
        {8'd8,  8'd1, 8'd1, 8'h06, 8'h00},
        {8'd5,  8'd0, 8'd1, 8'h33, 8'h00},
        {8'd4,  8'd6, 8'd2, 8'hC0, 8'h01}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              scl = 1'b1;
    logic              host_sda = 1'b1;
    logic              sda_line;
    logic              sda_oe;
    logic [NR*8-1:0]   cfg;

    int          n_chk = 0;
    int          n_bad = 0;
    bit          finished = 1'b0;
    logic [7:0]  model [NR];

    assign sda_line = host_sda & ~sda_oe;

    smb_blockcfg_slave u_smb_blockcfg_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl),
        .sda_in   (sda_line),
        .sda_oe   (sda_oe),
        .cfg_flat (cfg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    endtask

    task automatic wq(input int n);
        repeat (n*Q) @(negedge clk);
    endtask

    task automatic bus_start();
        if (!scl) begin
            host_sda = 1'b1; wq(1);
            scl = 1'b1;      wq(1);
        end
        host_sda = 1'b0; wq(1);
        scl = 1'b0;      wq(1);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; wq(1);
        scl = 1'b1;      wq(1);
        host_sda = 1'b1; wq(1);
    endtask

    task automatic put_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            host_sda = b[i]; wq(1);
            scl = 1'b1;      wq(2);
            scl = 1'b0;      wq(1);
        end
        host_sda = 1'b1; wq(1);
        scl = 1'b1;      wq(1);
        acked = ~sda_line;
        wq(1);
        scl = 1'b0;      wq(1);
    endtask

    task automatic get_byte(input bit ack, output logic [7:0] b);
        host_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(1);
            scl = 1'b1; wq(1);
            b[i] = sda_line;
            wq(1);
            scl = 1'b0;
        end
        host_sda = ack ? 1'b0 : 1'b1; wq(1);
        scl = 1'b1;                   wq(2);
        scl = 1'b0;                   wq(1);
        host_sda = 1'b1;
    endtask

    task automatic check_bank(input string tag);
        for (int i = 0; i < NR; i++) begin
            chk(cfg[i*8 +: 8] == model[i], tag, $sformatf("register %0d", i),
                32'(cfg[i*8 +: 8]), 32'(model[i]));
        end
    endtask

    task automatic wr_xfer(input logic [7:0] addr, input logic [7:0] idx, input logic [7:0] cnt,
                           input int nsend, input logic [7:0] base, input logic [7:0] step);
        bit         a;
        bit         ok;
        bit         exp;
        logic [7:0] d;
        ok = (addr == 8'hD0);
        bus_start();
        put_byte(addr, a);
        chk(a == ok, "R2", "address ack", 32'(a), 32'(ok));
        put_byte(idx, a);
        chk(a == ok, ok ? "R3" : "R2", "index ack", 32'(a), 32'(ok));
        put_byte(cnt, a);
        chk(a == ok, ok ? "R3" : "R2", "count ack", 32'(a), 32'(ok));
        for (int k = 0; k < nsend; k++) begin
            d   = base + 8'(k) * step;
            exp = ok && (k < int'(cnt));
            put_byte(d, a);
            chk(a == exp, !ok ? "R2" : (k < int'(cnt)) ? "R3" : "R4",
                $sformatf("data byte %0d ack", k), 32'(a), 32'(exp));
            if (exp) model[4'(idx + 8'(k))] = d;
        end
        bus_stop();
        wq(2);
    endtask

    task automatic rd_xfer(input logic [7:0] idx, input int nread);
        bit         a;
        logic [7:0] b;
        bus_start();
        put_byte(8'hD0, a);
        chk(a == 1'b1, "R5", "read setup address ack", 32'(a), 32'd1);
        put_byte(idx, a);
        chk(a == 1'b1, "R5", "read setup index ack", 32'(a), 32'd1);
        bus_start();
        put_byte(8'hD1, a);
        chk(a == 1'b1, "R5", "read address ack", 32'(a), 32'd1);
        get_byte(nread > 0, b);
        chk(b == model[8], (model[8] != 8'd16) ? "R8" : "R5", "count byte",
            32'(b), 32'(model[8]));
        for (int k = 0; k < nread; k++) begin
            get_byte(k < nread - 1, b);
            chk(b == model[4'(idx + 8'(k))], "R5", $sformatf("read byte %0d", k),
                32'(b), 32'(model[4'(idx + 8'(k))]));
        end
        get_byte(1'b0, b);
        chk(b == 8'hFF, "R6", "line after host nack", 32'(b), 32'hFF);
        bus_stop();
        wq(2);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        bit         a;
        logic [7:0] b;

        for (int i = 0; i < NR; i++) model[i] = (i == 8) ? 8'd16 : 8'd0;
        wq(2);
        rst_n = 1'b1;
        wq(1);

        // R1: reset contents and released line
        check_bank("R1");
        chk(sda_oe == 1'b0, "R1", "sda_oe after reset", 32'(sda_oe), 32'd0);

        // Vector walk: write a block, check the bank, read it back
        for (int e = 0; e < NV; e++) begin
            wr_xfer(8'hD0, VEC[e][39:32], VEC[e][31:24], int'(VEC[e][23:16]),
                    VEC[e][15:8], VEC[e][7:0]);
            check_bank((VEC[e][23:16] < VEC[e][31:24]) ? "R7" : "R3");
            rd_xfer(VEC[e][39:32], int'(model[8]));
        end

        // R2: foreign write address is ignored entirely
        wr_xfer(8'hA4, 8'd0, 8'd3, 3, 8'hEE, 8'h01);
        check_bank("R2");

        // R2: foreign read address gets no ack and no data
        bus_start();
        put_byte(8'hD3, a);
        chk(a == 1'b0, "R2", "foreign read address ack", 32'(a), 32'd0);
        get_byte(1'b0, b);
        chk(b == 8'hFF, "R2", "line after foreign address", 32'(b), 32'hFF);
        bus_stop();
        wq(2);

        // R7: repeated start cuts a write short and a new one proceeds
        bus_start();
        put_byte(8'hD0, a);
        put_byte(8'd10, a);
        put_byte(8'd3, a);
        put_byte(8'h5A, a);
        chk(a == 1'b1, "R7", "first byte before abort ack", 32'(a), 32'd1);
        model[10] = 8'h5A;
        bus_start();
        put_byte(8'hD0, a);
        chk(a == 1'b1, "R7", "address after restart ack", 32'(a), 32'd1);
        put_byte(8'd12, a);
        put_byte(8'd1, a);
        put_byte(8'hC3, a);
        model[12] = 8'hC3;
        put_byte(8'h99, a);
        chk(a == 1'b0, "R4", "byte past count ack", 32'(a), 32'd0);
        bus_stop();
        wq(2);
        check_bank("R7");

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule